// File: doc/BRIEF.md
# I2C Indirect Register Access Sequencer

This block reads and writes registers inside a remote device reached over I2C. The device exposes its registers through a pointer and data pair. It answers on two neighbouring 7-bit bus addresses, both derived from one base address. The even address (base times two) takes a register number into the device's pointer. The odd address (base times two plus one) moves one byte to or from the register that the pointer selects.

A request carries the base address, a register number, a direction flag and a write byte. The sequencer splits each request into two bus transactions. The first is START, the even address with the write bit, the register number, then STOP. The second is START, the odd address with the direction bit, one data byte, then STOP. It works only as master transmitter and master receiver. It drives a byte-level command port and waits on a completion strobe for each command, so bit timing belongs to the engine behind that port.

When a transfer ends it raises a one-cycle done pulse together with an error flag. Read data stays on its own output until the next successful read.

Top module: `i2c_ptr_regseq`

## Requirements
- R1: While reset is held and immediately after it, busy, done, err and cmd_valid are 0, and rd_data is 0.
- R2: A request is accepted on a clock edge where req_valid is 1 and busy is 0. From the next cycle, busy stays 1 until the cycle in which done is 1.
- R3: A request presented while busy is 1 has no effect on the commands of the transfer in progress. It does not start a transfer afterwards.
- R4: The first transaction is START, then WRITE of the byte {base, 1'b0, 1'b0}, then WRITE of the register number, then STOP. The address byte carries the even address (base*2) in bits 7:1 and the write bit 0 in bit 0.
- R5: The second transaction is START, then WRITE of {base, 1'b1, dir}, then the data step, then STOP. The odd address (base*2+1) sits in bits 7:1, and dir in bit 0 is 0 for a write and 1 for a read. On a write, the data step is WRITE of the request's write byte.
- R6: On a read, the data step is READ with cmd_nack = 1, so the master does not acknowledge the single byte. The byte returned with that command's cmd_done appears on rd_data together with done.
- R7: The command encoding on cmd_op is START = 0, STOP = 1, WRITE = 2, READ = 3. cmd_valid, cmd_op and cmd_wdata stay unchanged until the cycle in which cmd_done is 1.
- R8: If a WRITE command completes with cmd_ack = 0, the next command is STOP. After that STOP the transfer ends with err = 1, and no further command is issued.
- R9: done is a single-cycle pulse and busy is 0 in that cycle. err is valid with done and holds its value until the next request is accepted.
- R10: rd_data changes only when a READ command completes. A write access or a transfer that fails before its READ leaves rd_data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_base | input | 6 | Device base address |
| req_reg | input | 8 | Register number loaded into the device pointer |
| req_wdata | input | 8 | Byte written to the register |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last transfer saw a missing acknowledge |
| rd_data | output | 8 | Byte from the last successful read |
| cmd_valid | output | 1 | Byte-level command pending |
| cmd_op | output | 2 | Command code |
| cmd_wdata | output | 8 | Byte to send for WRITE |
| cmd_nack | output | 1 | Master answers the READ byte with not-acknowledge |
| cmd_done | input | 1 | Byte engine finished the pending command |
| cmd_ack | input | 1 | Slave acknowledged the written byte |
| cmd_rdata | input | 8 | Byte received by READ |

## Verification
The hardest case to reach is a missing acknowledge at each separate write position. These are the pointer address, the register number, the data address and the written data byte. Each one must cut the sequence short at a different point, and the abort must leave rd_data untouched. The bench's byte-engine model counts the commands of each transfer and withholds the acknowledge on a chosen index. The driver truncates its expected command list at that same index, so every abort point is compared command by command. The model also stretches its completion delay by command index, which keeps each command pending for several cycles while a stray request is pushed in during the transfer.

// File: rtl/i2c_regseq_pkg.sv
// Package: i2c_regseq_pkg
// Shared widths, byte-engine command codes and sequencer states for the
// indirect register access sequencer. Assumes 8-bit I2C bytes and 7-bit
// bus addresses; the device base is one bit narrower than the bus address.
package i2c_regseq_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = BYTE_W - 1;
    localparam int BASE_W = ADDR_W - 1;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_STOP  = 2'd1,
        OP_WRITE = 2'd2,
        OP_READ  = 2'd3
    } i2c_op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_P_START,
        ST_P_ADDR,
        ST_P_REG,
        ST_P_STOP,
        ST_D_START,
        ST_D_ADDR,
        ST_D_XFER,
        ST_D_STOP,
        ST_E_STOP
    } seq_state_e;
endpackage

// File: rtl/i2c_regseq_addr.sv
// Module: i2c_regseq_addr
// Forms the two address bytes of one register access from the device base.
// The pointer address is base*2 and the data address is base*2+1; bit 0 of
// each byte is the I2C direction bit. Purely combinational.
module i2c_regseq_addr
    import i2c_regseq_pkg::*;
(
    input  logic [BASE_W-1:0] base,
    input  logic              is_read,
    output logic [BYTE_W-1:0] ptr_byte,
    output logic [BYTE_W-1:0] dat_byte
);
    logic [ADDR_W-1:0] ptr_addr;
    logic [ADDR_W-1:0] dat_addr;

    // Derive the even and odd 7-bit bus addresses and append the direction bit.
    always_comb begin
        ptr_addr = {base, 1'b0};
        dat_addr = {base, 1'b1};
        ptr_byte = {ptr_addr, 1'b0};
        dat_byte = {dat_addr, is_read};
    end
endmodule

// File: rtl/i2c_regseq_ctx.sv
// Module: i2c_regseq_ctx
// Holds the accepted request for the length of a transfer and keeps the
// result outputs: the done pulse, the sticky error flag and the read byte.
// Assumes accept is only raised while the controller is idle.
module i2c_regseq_ctx
    import i2c_regseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              req_write,
    input  logic [BASE_W-1:0] req_base,
    input  logic [BYTE_W-1:0] req_reg,
    input  logic [BYTE_W-1:0] req_wdata,
    input  logic              fin,
    input  logic              fin_err,
    input  logic              rd_load,
    input  logic [BYTE_W-1:0] cmd_rdata,
    output logic              is_read,
    output logic [BASE_W-1:0] base_q,
    output logic [BYTE_W-1:0] reg_q,
    output logic [BYTE_W-1:0] wdata_q,
    output logic              done,
    output logic              err,
    output logic [BYTE_W-1:0] rd_data
);
    // Capture the request fields when a new transfer is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_read <= 1'b0;
            base_q  <= '0;
            reg_q   <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            is_read <= !req_write;
            base_q  <= req_base;
            reg_q   <= req_reg;
            wdata_q <= req_wdata;
        end
    end

    // Produce the completion pulse and keep the error flag until the next accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
            err  <= 1'b0;
        end else begin
            done <= fin;
            if (accept)
                err <= 1'b0;
            else if (fin)
                err <= fin_err;
        end
    end

    // Latch the byte returned by the single read command.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_load)
            rd_data <= cmd_rdata;
    end

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/i2c_regseq_ctrl.sv
// Module: i2c_regseq_ctrl
// State machine that walks one register access through the byte engine:
// pointer transaction, then data transaction, with an early STOP on any
// missing acknowledge. Each command is held until cmd_done; the engine is
// assumed to raise cmd_done for one cycle per command.
module i2c_regseq_ctrl
    import i2c_regseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              is_read,
    input  logic [BYTE_W-1:0] ptr_byte,
    input  logic [BYTE_W-1:0] dat_byte,
    input  logic [BYTE_W-1:0] reg_byte,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              cmd_done,
    input  logic              cmd_ack,
    output logic              accept,
    output logic              busy,
    output logic              cmd_valid,
    output i2c_op_e           cmd_op,
    output logic [BYTE_W-1:0] cmd_wdata,
    output logic              cmd_nack,
    output logic              fin,
    output logic              fin_err,
    output logic              rd_load
);
    seq_state_e state, state_nx;

    // Accept a request only when no transfer is running.
    always_comb begin
        busy   = (state != ST_IDLE);
        accept = req_valid && !busy;
    end

    // Map the current step to a byte-engine command.
    always_comb begin
        cmd_valid = busy;
        cmd_op    = OP_STOP;
        cmd_wdata = '0;
        cmd_nack  = 1'b0;
        unique case (state)
            ST_P_START, ST_D_START: cmd_op = OP_START;
            ST_P_ADDR: begin
                cmd_op    = OP_WRITE;
                cmd_wdata = ptr_byte;
            end
            ST_P_REG: begin
                cmd_op    = OP_WRITE;
                cmd_wdata = reg_byte;
            end
            ST_D_ADDR: begin
                cmd_op    = OP_WRITE;
                cmd_wdata = dat_byte;
            end
            ST_D_XFER: begin
                if (is_read) begin
                    cmd_op   = OP_READ;
                    cmd_nack = 1'b1;
                end else begin
                    cmd_op    = OP_WRITE;
                    cmd_wdata = wr_byte;
                end
            end
            default: cmd_op = OP_STOP;
        endcase
    end

    // Choose the next step when the engine reports the current command done.
    always_comb begin
        state_nx = state;
        fin      = 1'b0;
        fin_err  = 1'b0;
        rd_load  = 1'b0;
        unique case (state)
            ST_IDLE:    if (accept) state_nx = ST_P_START;
            ST_P_START: if (cmd_done) state_nx = ST_P_ADDR;
            ST_P_ADDR:  if (cmd_done) state_nx = cmd_ack ? ST_P_REG : ST_E_STOP;
            ST_P_REG:   if (cmd_done) state_nx = cmd_ack ? ST_P_STOP : ST_E_STOP;
            ST_P_STOP:  if (cmd_done) state_nx = ST_D_START;
            ST_D_START: if (cmd_done) state_nx = ST_D_ADDR;
            ST_D_ADDR:  if (cmd_done) state_nx = cmd_ack ? ST_D_XFER : ST_E_STOP;
            ST_D_XFER: begin
                if (cmd_done) begin
                    if (is_read) begin
                        rd_load  = 1'b1;
                        state_nx = ST_D_STOP;
                    end else begin
                        state_nx = cmd_ack ? ST_D_STOP : ST_E_STOP;
                    end
                end
            end
            ST_D_STOP: begin
                if (cmd_done) begin
                    fin      = 1'b1;
                    state_nx = ST_IDLE;
                end
            end
            ST_E_STOP: begin
                if (cmd_done) begin
                    fin      = 1'b1;
                    fin_err  = 1'b1;
                    state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Advance the sequencer state.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // R7
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_done) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_wdata)));

    // R8
    nack_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_done && cmd_op == OP_WRITE && !cmd_ack) |=> (cmd_valid && cmd_op == OP_STOP));

    // R2
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));
endmodule

// File: rtl/i2c_ptr_regseq.sv
// Module: i2c_ptr_regseq
// Top of the indirect register access sequencer. Accepts one request at a
// time and turns it into a pointer write and a data transfer on two
// neighbouring I2C addresses through a byte-level command port.
// Assumes the byte engine behind cmd_* owns all bit timing.
module i2c_ptr_regseq
    import i2c_regseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [BASE_W-1:0] req_base,
    input  logic [BYTE_W-1:0] req_reg,
    input  logic [BYTE_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [BYTE_W-1:0] rd_data,
    output logic              cmd_valid,
    output logic [1:0]        cmd_op,
    output logic [BYTE_W-1:0] cmd_wdata,
    output logic              cmd_nack,
    input  logic              cmd_done,
    input  logic              cmd_ack,
    input  logic [BYTE_W-1:0] cmd_rdata
);
    logic              accept_w, fin_w, fin_err_w, rd_load_w, is_read_w;
    logic [BASE_W-1:0] base_w;
    logic [BYTE_W-1:0] reg_w, wdata_w, ptr_byte_w, dat_byte_w;
    i2c_op_e           op_w;

    i2c_regseq_ctx u_ctx (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept_w),
        .req_write (req_write),
        .req_base  (req_base),
        .req_reg   (req_reg),
        .req_wdata (req_wdata),
        .fin       (fin_w),
        .fin_err   (fin_err_w),
        .rd_load   (rd_load_w),
        .cmd_rdata (cmd_rdata),
        .is_read   (is_read_w),
        .base_q    (base_w),
        .reg_q     (reg_w),
        .wdata_q   (wdata_w),
        .done      (done),
        .err       (err),
        .rd_data   (rd_data)
    );

    i2c_regseq_addr u_addr (
        .base     (base_w),
        .is_read  (is_read_w),
        .ptr_byte (ptr_byte_w),
        .dat_byte (dat_byte_w)
    );

    i2c_regseq_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .is_read   (is_read_w),
        .ptr_byte  (ptr_byte_w),
        .dat_byte  (dat_byte_w),
        .reg_byte  (reg_w),
        .wr_byte   (wdata_w),
        .cmd_done  (cmd_done),
        .cmd_ack   (cmd_ack),
        .accept    (accept_w),
        .busy      (busy),
        .cmd_valid (cmd_valid),
        .cmd_op    (op_w),
        .cmd_wdata (cmd_wdata),
        .cmd_nack  (cmd_nack),
        .fin       (fin_w),
        .fin_err   (fin_err_w),
        .rd_load   (rd_load_w)
    );

    // Present the command code as a plain vector at the port.
    always_comb cmd_op = op_w;

    // R10
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && cmd_done && cmd_op == OP_READ) |=> $stable(rd_data));

    // R3
    ctx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || $stable(base_w)));

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

// File: tb/i2c_ptr_regseq_bench.sv
module i2c_ptr_regseq_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0, req_write = 1'b0;
    logic [5:0] req_base = '0;
    logic [7:0] req_reg = '0, req_wdata = '0;
    logic       busy, done, err, cmd_valid, cmd_nack;
    logic [7:0] rd_data, cmd_wdata;
    logic [1:0] cmd_op;
    logic       cmd_done = 1'b0, cmd_ack = 1'b0;
    logic [7:0] cmd_rdata = '0;

    typedef struct { logic [1:0] op; logic [7:0] data; string tag; } exp_cmd_t;
    typedef struct { logic err; logic [7:0] rd; } exp_res_t;
    exp_cmd_t cmd_q[$];
    exp_res_t res_q[$];

    int checks = 0, fails = 0, done_cnt = 0;
    int cmd_idx = 0, nack_at = -1;
    logic [7:0] slave_rd = '0, model_rd = '0;

    always #2 clk = ~clk;

    i2c_ptr_regseq u_i2c_ptr_regseq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_base(req_base), .req_reg(req_reg), .req_wdata(req_wdata),
        .busy(busy), .done(done), .err(err), .rd_data(rd_data),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_wdata(cmd_wdata),
        .cmd_nack(cmd_nack), .cmd_done(cmd_done), .cmd_ack(cmd_ack),
        .cmd_rdata(cmd_rdata)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [1:0] op, input logic [7:0] d, input string tag);
        exp_cmd_t e;
        e.op = op; e.data = d; e.tag = tag;
        cmd_q.push_back(e);
    endtask

    // Byte-engine model: pops the scoreboard for every command it serves.
    initial begin
        int d;
        exp_cmd_t e;
        forever begin
            @(negedge clk);
            if (cmd_valid) begin
                d = (cmd_idx * 2 + 1) % 4;   // R7: stretch the command before completion
                repeat (d) @(negedge clk);
                if (cmd_q.size() == 0) begin
                    chk(1'b0, "R8 unexpected command", cmd_op, 4);
                end else begin
                    e = cmd_q.pop_front();
                    chk(cmd_op == e.op, {e.tag, " op"}, cmd_op, e.op);
                    if (e.op == 2'd2) chk(cmd_wdata == e.data, {e.tag, " byte"}, cmd_wdata, e.data);
                    if (e.op == 2'd3) chk(cmd_nack == 1'b1, "R6 nack", cmd_nack, 1);
                end
                cmd_ack   = !(cmd_op == 2'd2 && cmd_idx == nack_at);
                cmd_rdata = slave_rd;
                cmd_done  = 1'b1;
                cmd_idx++;
                @(negedge clk);
                cmd_done = 1'b0;
            end
        end
    end

    // Result monitor: compares each done pulse with the scoreboard.
    initial begin
        exp_res_t r;
        forever begin
            @(negedge clk);
            if (done) begin
                if (res_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected done", 1, 0);
                end else begin
                    r = res_q.pop_front();
                    chk(err == r.err, "R9 err", err, r.err);
                    chk(rd_data == r.rd, "R10 rd_data", rd_data, r.rd);
                    chk(!busy, "R9 busy with done", busy, 0);
                end
                done_cnt++;
            end
        end
    end

    // Driver: builds the expected command list, then issues the request.
    task automatic access(input logic [5:0] b, input logic [7:0] rg, input bit wr,
                          input logic [7:0] wd, input logic [7:0] sd, input int nk,
                          input bit poke);
        bit e = 1'b0;
        int start;
        exp_res_t r;
        push(2'd0, 8'h00, "R4");
        push(2'd2, {b, 2'b00}, "R4");
        if (nk == 1) e = 1'b1;
        else begin
            push(2'd2, rg, "R4");
            if (nk == 2) e = 1'b1;
            else begin
                push(2'd1, 8'h00, "R4");
                push(2'd0, 8'h00, "R5");
                push(2'd2, {b, 1'b1, !wr}, "R5");
                if (nk == 5) e = 1'b1;
                else if (wr) begin
                    push(2'd2, wd, "R5");
                    if (nk == 6) e = 1'b1;
                end else begin
                    push(2'd3, 8'h00, "R6");
                end
            end
        end
        push(2'd1, 8'h00, e ? "R8" : "R5");
        if (!wr && !e) model_rd = sd;
        r.err = e; r.rd = model_rd;
        res_q.push_back(r);
        nack_at = nk; slave_rd = sd; cmd_idx = 0;
        start = done_cnt;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_base = b; req_reg = rg; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R2 busy after accept", busy, 1);
        if (poke) begin   // R3: stray request during the transfer
            req_valid = 1'b1; req_write = !wr; req_base = b ^ 6'h2A; req_reg = ~rg;
            repeat (3) @(negedge clk);
            req_valid = 1'b0;
        end
        while (done_cnt == start) @(negedge clk);
        chk(cmd_q.size() == 0, "R8 commands left", cmd_q.size(), 0);
    endtask

    task automatic idle_check(input string tag);
        bit ok = 1'b1;
        repeat (10) begin
            @(negedge clk);
            if (cmd_valid || busy || done) ok = 1'b0;
        end
        chk(ok, tag, cmd_valid, 0);
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy && !done && !err && !cmd_valid && rd_data == 8'h00, "R1 reset", {busy, done, err, cmd_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !cmd_valid && rd_data == 8'h00, "R1 after reset", {busy, cmd_valid}, 0);
        access(6'h15, 8'h2A, 1'b1, 8'hC3, 8'h00, -1, 1'b0);
        access(6'h3F, 8'h00, 1'b0, 8'h00, 8'h5A, -1, 1'b0);  // R6
        access(6'h0C, 8'h71, 1'b1, 8'h99, 8'h00, -1, 1'b1);  // R3
        idle_check("R3 no stale start");
        access(6'h21, 8'h10, 1'b0, 8'h00, 8'hEE, 1, 1'b0);   // R8 pointer address
        access(6'h02, 8'h33, 1'b1, 8'h44, 8'h00, 2, 1'b0);   // R8 register byte
        access(6'h2E, 8'h08, 1'b0, 8'h00, 8'h77, 5, 1'b0);   // R8 data address
        access(6'h11, 8'hF0, 1'b1, 8'h0F, 8'h00, 6, 1'b0);   // R8 data byte, R10
        access(6'h00, 8'hFF, 1'b0, 8'h00, 8'hA5, -1, 1'b0);  // R9 err clears
        access(6'h3A, 8'h81, 1'b1, 8'h18, 8'h00, -1, 1'b1);  // R10 write keeps rd_data
        idle_check("R3 idle after poke");
        chk(err == 1'b0, "R9 err held", err, 0);
        chk(res_q.size() == 0, "R9 results pending", res_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule